// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block decides which clock domains of a small processor core are allowed to run. Software first loads a four-bit control word that holds a sleep-enable flag and a three-bit sleep mode. It then issues a one-cycle sleep strobe. If the flag is set and the mode code is valid, the block enters the chosen mode on the next edge. In that mode it drops a registered, glitch-free enable for each of six domains: CPU, program memory (flash), general I/O peripherals, ADC, asynchronous timer and main oscillator.

Six wake inputs come in already qualified by the interrupt controller as pending and enabled. Each sleep mode accepts its own subset of them. An accepted wake starts a wake-up sequence. The non-CPU domains come back at once. The CPU and flash enables stay low through a mode-dependent start-up count followed by a fixed four-cycle halt. When they return, a one-cycle pulse tells the core to service the interrupt and then carry on after the sleep request. A core reset request arriving while the CPU is stopped cuts the sequence short. The block returns to active at once and signals a reset-vector restart instead.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: A cycle with `cfg_we` high loads the control word from `cfg_wdata`: bit 3 is the sleep-enable flag and bits 2:0 the mode code.
- R2: While `sleeping` is low all six `clk_en` bits are 1. A `sleep_req` with the flag at 1 and a valid mode code sets `sleeping` and applies that mode's enable vector on the next edge. Bit order of `clk_en`: 0 CPU, 1 flash, 2 I/O, 3 ADC, 4 async timer, 5 oscillator.
- R3: A `sleep_req` with the flag at 0, or with mode code 100 or 101, is ignored and the block stays active.
- R4: Code 000 (idle) gives `clk_en` = 6'b111100, so only CPU and flash are stopped.
- R5: Code 001 gives 6'b111000. Code 010 (power-down) gives 6'b000000. Code 011 gives {0, async, 0000}. Code 110 gives 6'b100000. Code 111 gives {1, async, 0000}. Whenever the oscillator bit is 0, bits 3:0 are 0.
- R6: In codes 011 and 111 the async-timer enable follows `tmr_async` one edge later for as long as the block sleeps.
- R7: The wake sources are accepted as follows. `irq_ext` and `irq_hi_lvl` wake from every mode. `irq_adc` wakes from codes 000 and 001. `irq_io` wakes from 000 only. `irq_tmr` wakes from 000 and 001, and also from 011 and 111 when `tmr_async` is 1. Any other source is ignored and the sleep vector is kept.
- R8: `irq_hi_edge` (edge-detected upper external lines) wakes only from codes 000 and 001. In every other mode only the level-type `irq_hi_lvl` wakes the core.
- R9: After a wake is sampled, `clk_en` is 6'b111100. CPU and flash return S+4 edges after the sampling edge. S is SU_IDLE for 000, SU_ADC for 001, SU_DEEP for 010 and 011, and SU_STBY for 110 and 111.
- R10: `wake_irq` is a one-cycle pulse in the first cycle the CPU enable is back. It never coincides with `wake_rst`.
- R11: `rst_req` while sleeping or waking returns the block to active on the next edge with all enables on and a one-cycle `wake_rst`, and no `wake_irq` follows. It takes priority over a wake in the same cycle. While active it has no effect.
- R12: A low `rst_n` at an edge forces the active state, all enables on, the control word to 0 and both pulses low.
- R13: The mode is captured at sleep entry, so a control write during sleep leaves the enables unchanged. A write in the same cycle as `sleep_req` takes effect only for later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 4 | Control word: [3] sleep enable, [2:0] mode |
| sleep_req | input | 1 | Sleep request strobe from the core |
| rst_req | input | 1 | Core reset request (reset wake) |
| tmr_async | input | 1 | Async timer is running from its own clock |
| irq_ext | input | 1 | Wake: low external lines, pin change, serial address match, watchdog |
| irq_hi_lvl | input | 1 | Wake: upper external lines, level type |
| irq_hi_edge | input | 1 | Wake: upper external lines, edge type |
| irq_tmr | input | 1 | Wake: async timer |
| irq_adc | input | 1 | Wake: ADC conversion done |
| irq_io | input | 1 | Wake: clocked I/O peripherals |
| clk_en | output | 6 | Registered per-domain clock enables |
| sleeping | output | 1 | CPU is stopped (sleep or wake-up sequence) |
| wake_irq | output | 1 | One-cycle pulse: service the waking interrupt |
| wake_rst | output | 1 | One-cycle pulse: restart from the reset vector |

## Verification
Two things can happen in the same cycle: a core reset request and an accepted interrupt wake. The bench provokes this by raising `rst_req` and `irq_ext` together while the block sleeps in standby. It expects `wake_rst`, all enables on and no `wake_irq`, neither on that edge nor over the following start-up window. A second case raises the reset request partway through a start-up count. A control write issued in the same cycle as the sleep strobe is also checked: the strobe must still follow the previous mode.

// File: rtl/slpc_pkg.sv
// Package: shared constants and types for the sleep clock controller.
// Assumes: clock-enable bit positions are fixed and decoded by the clock tree.
package slpc_pkg;

    localparam int DOM_N    = 6;
    localparam int D_CPU    = 0;
    localparam int D_FLASH  = 1;
    localparam int D_IO     = 2;
    localparam int D_ADC    = 3;
    localparam int D_ASY    = 4;
    localparam int D_OSC    = 5;
    localparam int HALT_CYC = 4;

    // Enables during the wake-up sequence: everything but CPU and flash.
    localparam logic [DOM_N-1:0] WAKE_VEC = 6'b111100;
    localparam logic [DOM_N-1:0] ALL_ON   = 6'b111111;

    typedef enum logic [2:0] {
        M_IDLE  = 3'b000,
        M_ADCNR = 3'b001,
        M_PDOWN = 3'b010,
        M_PSAVE = 3'b011,
        M_RSV4  = 3'b100,
        M_RSV5  = 3'b101,
        M_STBY  = 3'b110,
        M_XSTBY = 3'b111
    } slp_mode_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_START = 2'd2,
        ST_HALT  = 2'd3
    } slp_state_e;

    typedef struct packed {
        logic ext;
        logic hi_lvl;
        logic hi_edge;
        logic tmr;
        logic adc;
        logic io;
    } wake_src_t;

endpackage

// File: rtl/slpc_mode_decode.sv
// Module: slpc_mode_decode
// Turns a mode code into its validity, per-domain enable vector and start-up
// count (stored as count-1). Purely combinational.
// Assumes: every SU_* parameter is at least 1 and fits in CNT_W bits.
module slpc_mode_decode
    import slpc_pkg::*;
#(
    parameter int SU_IDLE = 2,
    parameter int SU_ADC  = 3,
    parameter int SU_STBY = 6,
    parameter int SU_DEEP = 40,
    parameter int CNT_W   = 6
) (
    input  logic [2:0]       mode,
    input  logic             tmr_async,
    output logic             mode_ok,
    output logic [DOM_N-1:0] dom_en,
    output logic [CNT_W-1:0] su_load
);

    localparam logic [CNT_W-1:0] L_IDLE = CNT_W'(SU_IDLE - 1);
    localparam logic [CNT_W-1:0] L_ADC  = CNT_W'(SU_ADC - 1);
    localparam logic [CNT_W-1:0] L_STBY = CNT_W'(SU_STBY - 1);
    localparam logic [CNT_W-1:0] L_DEEP = CNT_W'(SU_DEEP - 1);

    // Mode lookup: enables, start-up length and validity.
    always_comb begin
        mode_ok = 1'b1;
        dom_en  = ALL_ON;
        su_load = L_IDLE;
        case (mode)
            M_IDLE: begin
                dom_en  = 6'b111100;
                su_load = L_IDLE;
            end
            M_ADCNR: begin
                dom_en  = 6'b111000;
                su_load = L_ADC;
            end
            M_PDOWN: begin
                dom_en  = 6'b000000;
                su_load = L_DEEP;
            end
            M_PSAVE: begin
                dom_en  = {1'b0, tmr_async, 4'b0000};
                su_load = L_DEEP;
            end
            M_STBY: begin
                dom_en  = 6'b100000;
                su_load = L_STBY;
            end
            M_XSTBY: begin
                dom_en  = {1'b1, tmr_async, 4'b0000};
                su_load = L_STBY;
            end
            default: begin
                mode_ok = 1'b0;
                dom_en  = ALL_ON;
                su_load = L_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/slpc_wake_qual.sv
// Module: slpc_wake_qual
// Filters the pending-and-enabled wake sources by what the current sleep mode
// can still detect. Purely combinational.
// Assumes: sources are already synchronised and enabled upstream.
module slpc_wake_qual
    import slpc_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       tmr_async,
    input  wake_src_t  src,
    output logic       wake
);

    logic is_idle;
    logic is_adc;
    logic light;
    logic tmr_ok;

    // Mode class flags.
    always_comb begin
        is_idle = (mode == M_IDLE);
        is_adc  = (mode == M_ADCNR);
        light   = is_idle | is_adc;
        tmr_ok  = light | (((mode == M_PSAVE) | (mode == M_XSTBY)) & tmr_async);
    end

    // Source acceptance: level-type and clockless sources work everywhere.
    always_comb begin
        wake = src.ext
             | src.hi_lvl
             | (light & (src.hi_edge | src.adc))
             | (is_idle & src.io)
             | (tmr_ok & src.tmr);
    end

endmodule

// File: rtl/slpc_wake_timer.sv
// Module: slpc_wake_timer
// Down-counter shared by the start-up wait and the fixed halt.
// Assumes: load has priority; the count parks at zero.
module slpc_wake_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             cnt_zero
);

    logic [CNT_W-1:0] cnt;

    // Load or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign cnt_zero = (cnt == '0);

endmodule

// File: rtl/sleep_clk_ctrl.sv
// Module: sleep_clk_ctrl (top)
// Holds the sleep control word, sequences run/sleep/start-up/halt and drives
// registered per-domain clock enables and the two wake pulses.
// Assumes: sleep_req and rst_req are synchronous to clk; wake sources arrive
// pending-and-enabled from the interrupt controller.
module sleep_clk_ctrl
    import slpc_pkg::*;
#(
    parameter int SU_IDLE = 2,
    parameter int SU_ADC  = 3,
    parameter int SU_STBY = 6,
    parameter int SU_DEEP = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_wdata,
    input  logic             sleep_req,
    input  logic             rst_req,
    input  logic             tmr_async,
    input  logic             irq_ext,
    input  logic             irq_hi_lvl,
    input  logic             irq_hi_edge,
    input  logic             irq_tmr,
    input  logic             irq_adc,
    input  logic             irq_io,
    output logic [DOM_N-1:0] clk_en,
    output logic             sleeping,
    output logic             wake_irq,
    output logic             wake_rst
);

    localparam int MAX_A  = (SU_IDLE > SU_ADC) ? SU_IDLE : SU_ADC;
    localparam int MAX_B  = (SU_STBY > SU_DEEP) ? SU_STBY : SU_DEEP;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int SU_MAX = (MAX_C > HALT_CYC) ? MAX_C : HALT_CYC;
    localparam int CNT_W  = $clog2(SU_MAX + 1);
    localparam logic [CNT_W-1:0] HALT_LOAD = CNT_W'(HALT_CYC - 1);

    logic             ctl_se;
    logic [2:0]       ctl_mode;
    logic [2:0]       slp_mode;
    slp_state_e       st, st_n;
    logic [2:0]       dec_mode;
    logic             dec_ok;
    logic [DOM_N-1:0] dec_vec;
    logic [CNT_W-1:0] dec_su;
    logic             wake;
    wake_src_t        src;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             capture;
    logic             wirq_n;
    logic             wrst_n;
    logic [DOM_N-1:0] en_n;

    assign src.ext     = irq_ext;
    assign src.hi_lvl  = irq_hi_lvl;
    assign src.hi_edge = irq_hi_edge;
    assign src.tmr     = irq_tmr;
    assign src.adc     = irq_adc;
    assign src.io      = irq_io;

    // Control word register written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_se   <= 1'b0;
            ctl_mode <= 3'b000;
        end else if (cfg_we) begin
            ctl_se   <= cfg_wdata[3];
            ctl_mode <= cfg_wdata[2:0];
        end
    end

    // Decoder input: requested mode while running, captured mode otherwise.
    assign dec_mode = (st == ST_RUN) ? ctl_mode : slp_mode;

    slpc_mode_decode #(
        .SU_IDLE (SU_IDLE),
        .SU_ADC  (SU_ADC),
        .SU_STBY (SU_STBY),
        .SU_DEEP (SU_DEEP),
        .CNT_W   (CNT_W)
    ) u_dec (
        .mode      (dec_mode),
        .tmr_async (tmr_async),
        .mode_ok   (dec_ok),
        .dom_en    (dec_vec),
        .su_load   (dec_su)
    );

    slpc_wake_qual u_qual (
        .mode      (slp_mode),
        .tmr_async (tmr_async),
        .src       (src),
        .wake      (wake)
    );

    slpc_wake_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt_zero (tmr_zero)
    );

    // Next-state logic; a reset request overrides every other transition.
    always_comb begin
        st_n     = st;
        tmr_load = 1'b0;
        tmr_val  = dec_su;
        capture  = 1'b0;
        wirq_n   = 1'b0;
        wrst_n   = 1'b0;
        case (st)
            ST_RUN: begin
                if (sleep_req && ctl_se && dec_ok) begin
                    st_n    = ST_SLEEP;
                    capture = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (wake) begin
                    st_n     = ST_START;
                    tmr_load = 1'b1;
                    tmr_val  = dec_su;
                end
            end
            ST_START: begin
                if (tmr_zero) begin
                    st_n     = ST_HALT;
                    tmr_load = 1'b1;
                    tmr_val  = HALT_LOAD;
                end
            end
            ST_HALT: begin
                if (tmr_zero) begin
                    st_n   = ST_RUN;
                    wirq_n = 1'b1;
                end
            end
            default: st_n = ST_RUN;
        endcase
        if (st != ST_RUN && rst_req) begin
            st_n     = ST_RUN;
            tmr_load = 1'b0;
            wirq_n   = 1'b0;
            wrst_n   = 1'b1;
        end
    end

    // Enable vector that the next state calls for.
    always_comb begin
        case (st_n)
            ST_RUN:   en_n = ALL_ON;
            ST_SLEEP: en_n = dec_vec;
            default:  en_n = WAKE_VEC;
        endcase
    end

    // State, captured mode and wake pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_RUN;
            slp_mode <= 3'b000;
            sleeping <= 1'b0;
            wake_irq <= 1'b0;
            wake_rst <= 1'b0;
        end else begin
            st       <= st_n;
            sleeping <= (st_n != ST_RUN);
            wake_irq <= wirq_n;
            wake_rst <= wrst_n;
            if (capture) begin
                slp_mode <= ctl_mode;
            end
        end
    end

    // One glitch-free enable flop per clock domain.
    for (genvar d = 0; d < DOM_N; d++) begin : g_en
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                clk_en[d] <= 1'b1;
            end else begin
                clk_en[d] <= en_n[d];
            end
        end
    end

endmodule

// File: rtl/slpc_checker.sv
// Module: slpc_checker
// Temporal checks on the controller's outputs, bound into every instance.
// Assumes: synchronous active-low reset on rst_n.
module slpc_checker
    import slpc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_req,
    input logic             rst_req,
    input logic             ctl_se,
    input logic [DOM_N-1:0] clk_en,
    input logic             sleeping,
    input logic             wake_irq,
    input logic             wake_rst
);

    assert_awake_all_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sleeping |-> (clk_en == ALL_ON));

    assert_se_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping && sleep_req && !ctl_se) |=> !sleeping);

    assert_osc_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en[D_OSC] |-> (clk_en[D_ADC:D_CPU] == 4'b0000));

    assert_halt_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> !$past(clk_en[D_CPU], 4));

    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> ($rose(clk_en[D_CPU]) && !wake_rst));

    assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !wake_irq);

    assert_rst_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && rst_req) |=> (!sleeping && wake_rst && !wake_irq));

    assert_rst_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping && rst_req) |=> !wake_rst);

endmodule

bind sleep_clk_ctrl slpc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .rst_req   (rst_req),
    .ctl_se    (ctl_se),
    .clk_en    (clk_en),
    .sleeping  (sleeping),
    .wake_irq  (wake_irq),
    .wake_rst  (wake_rst)
);

// File: tb/sleep_clk_ctrl_tb.sv
// Bench: directed corner cases plus seeded random sleep/wake episodes.
module sleep_clk_ctrl_tb;

    localparam int P_IDLE = 2;
    localparam int P_ADC  = 3;
    localparam int P_STBY = 6;
    localparam int P_DEEP = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = 4'h0;
    logic       sleep_req = 1'b0;
    logic       rst_req = 1'b0;
    logic       tmr_async = 1'b0;
    logic       irq_ext = 1'b0, irq_hi_lvl = 1'b0, irq_hi_edge = 1'b0;
    logic       irq_tmr = 1'b0, irq_adc = 1'b0, irq_io = 1'b0;
    logic [5:0] clk_en;
    logic       sleeping, wake_irq, wake_rst;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sleep_clk_ctrl #(
        .SU_IDLE (P_IDLE), .SU_ADC (P_ADC), .SU_STBY (P_STBY), .SU_DEEP (P_DEEP)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .sleep_req (sleep_req), .rst_req (rst_req), .tmr_async (tmr_async),
        .irq_ext (irq_ext), .irq_hi_lvl (irq_hi_lvl), .irq_hi_edge (irq_hi_edge),
        .irq_tmr (irq_tmr), .irq_adc (irq_adc), .irq_io (irq_io),
        .clk_en (clk_en), .sleeping (sleeping), .wake_irq (wake_irq), .wake_rst (wake_rst)
    );

    // Expected enable vector per mode (R4, R5, R6).
    function automatic logic [5:0] f_vec(logic [2:0] m, logic a);
        case (m)
            3'd0:    return 6'b111100;
            3'd1:    return 6'b111000;
            3'd2:    return 6'b000000;
            3'd3:    return {1'b0, a, 4'b0000};
            3'd6:    return 6'b100000;
            3'd7:    return {1'b1, a, 4'b0000};
            default: return 6'b111111;
        endcase
    endfunction

    function automatic bit f_valid(logic [2:0] m);
        return !(m == 3'd4 || m == 3'd5);
    endfunction

    // Source bits: 0 ext, 1 hi_lvl, 2 hi_edge, 3 tmr, 4 adc, 5 io (R7, R8).
    function automatic bit f_wake(logic [2:0] m, logic a, logic [5:0] s);
        bit light = (m == 3'd0) || (m == 3'd1);
        bit t_ok  = light || (((m == 3'd3) || (m == 3'd7)) && a);
        return s[0] || s[1] || (light && (s[2] || s[4])) ||
               ((m == 3'd0) && s[5]) || (t_ok && s[3]);
    endfunction

    function automatic int f_su(logic [2:0] m);
        case (m)
            3'd0:       return P_IDLE;
            3'd1:       return P_ADC;
            3'd2, 3'd3: return P_DEEP;
            default:    return P_STBY;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_irq(logic [5:0] v);
        irq_ext = v[0]; irq_hi_lvl = v[1]; irq_hi_edge = v[2];
        irq_tmr = v[3]; irq_adc = v[4]; irq_io = v[5];
    endtask

    task automatic wr(logic se, logic [2:0] m);
        cfg_we = 1'b1; cfg_wdata = {se, m};
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic req_sleep();
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
    endtask

    // Present an accepted wake source and time the CPU return (R9, R10).
    task automatic wake_and_time(logic [2:0] m, logic [5:0] s);
        int k = 0;
        set_irq(s);
        tick();
        set_irq(6'b0);
        chk("R9 wake vector", {26'b0, clk_en}, 32'h3C);
        while (clk_en[0] == 1'b0 && k < 400) begin
            tick();
            k++;
        end
        chk("R9 start-up plus halt", k, f_su(m) + 4);
        chk("R10 wake_irq pulse", wake_irq, 1);
        chk("R10 no wake_rst", wake_rst, 0);
        tick();
        chk("R10 pulse ends", wake_irq, 0);
        chk("R2 awake", sleeping, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7193));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R12 reset state
        chk("R12 enables", {26'b0, clk_en}, 32'h3F);
        chk("R12 sleeping", sleeping, 0);
        chk("R12 pulses", {wake_irq, wake_rst}, 0);
        req_sleep();
        chk("R12 flag cleared", sleeping, 0);

        // R3 flag clear, reserved codes
        wr(1'b0, 3'd0); req_sleep();
        chk("R3 flag off", sleeping, 0);
        wr(1'b1, 3'd4); req_sleep();
        chk("R3 code 100", {25'b0, sleeping, clk_en}, 32'h3F);
        wr(1'b1, 3'd5); req_sleep();
        chk("R3 code 101", sleeping, 0);

        // R13 write and strobe in one cycle: old mode (idle) applies
        wr(1'b1, 3'd0);
        cfg_we = 1'b1; cfg_wdata = 4'b1010; sleep_req = 1'b1;
        tick();
        cfg_we = 1'b0; sleep_req = 1'b0;
        chk("R13 same-cycle write", {26'b0, clk_en}, 32'h3C);
        wr(1'b1, 3'd3);
        chk("R13 write during sleep", {26'b0, clk_en}, 32'h3C);
        wake_and_time(3'd0, 6'b100000);
        tmr_async = 1'b0;
        req_sleep();
        chk("R1 new mode 011", {26'b0, clk_en}, {26'b0, f_vec(3'd3, 1'b0)});

        // R6 async timer enable follows live input
        tmr_async = 1'b1; tick();
        chk("R6 async on", {26'b0, clk_en}, 32'h10);
        tmr_async = 1'b0; tick();
        chk("R6 async off", {26'b0, clk_en}, 32'h00);
        set_irq(6'b001000); tick(); set_irq(6'b0);
        chk("R7 timer ignored without async", sleeping, 1);
        tmr_async = 1'b1; tick();
        wake_and_time(3'd3, 6'b001000);

        // R8 power-down: edge ignored, level wakes
        wr(1'b1, 3'd2); req_sleep();
        chk("R5 power-down", {26'b0, clk_en}, 32'h00);
        set_irq(6'b000100); tick(); set_irq(6'b0);
        chk("R8 edge ignored", {25'b0, sleeping, clk_en}, 32'h40);
        wake_and_time(3'd2, 6'b000010);

        // R11 reset request together with interrupt in standby
        wr(1'b1, 3'd6); req_sleep();
        chk("R5 standby", {26'b0, clk_en}, 32'h20);
        set_irq(6'b000001); rst_req = 1'b1; tick(); set_irq(6'b0); rst_req = 1'b0;
        chk("R11 reset wins", {24'b0, sleeping, wake_irq, clk_en}, 32'h3F);
        chk("R11 wake_rst", wake_rst, 1);
        tick();
        chk("R11 wake_rst ends", wake_rst, 0);
        // R11 reset request during start-up
        req_sleep();
        set_irq(6'b000001); tick(); set_irq(6'b0);
        tick();
        rst_req = 1'b1; tick(); rst_req = 1'b0;
        chk("R11 abort start-up", {24'b0, sleeping, wake_rst, clk_en}, 32'h7F);
        for (int i = 0; i < 12; i++) begin
            tick();
            chk("R11 no late wake_irq", wake_irq, 0);
        end
        rst_req = 1'b1; tick(); rst_req = 1'b0;
        chk("R11 ignored while active", {24'b0, sleeping, wake_rst, clk_en}, 32'h3F);

        // Random episodes
        for (int ep = 0; ep < 300; ep++) begin
            logic [2:0] m  = 3'($urandom % 8);
            logic       se = (($urandom % 4) != 0);
            logic       a  = 1'($urandom % 2);
            bit         woke = 0;
            tmr_async = a;
            wr(se, m);
            req_sleep();
            if (!(se && f_valid(m))) begin
                chk("R3 random ignore", {25'b0, sleeping, clk_en}, 32'h3F);
                continue;
            end
            chk(m == 3'd0 ? "R4 idle vector" : "R5 mode vector",
                {25'b0, sleeping, clk_en}, {25'b0, 1'b1, f_vec(m, a)});
            for (int c = 0; c < 12 && !woke; c++) begin
                logic [5:0] s = 6'($urandom & $urandom & $urandom);
                if (f_wake(m, a, s)) begin
                    wake_and_time(m, s);
                    woke = 1;
                end else begin
                    set_irq(s); tick(); set_irq(6'b0);
                    chk("R7 source ignored", {25'b0, sleeping, clk_en},
                        {25'b0, 1'b1, f_vec(m, a)});
                end
            end
            if (!woke) wake_and_time(m, 6'b000001);
        end

        // R12 reset while asleep
        wr(1'b1, 3'd2); req_sleep();
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
        chk("R12 reset in sleep", {24'b0, sleeping, wake_rst, clk_en}, 32'h3F);
        req_sleep();
        chk("R12 control word cleared", sleeping, 0);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule